// File: doc/BRIEF.md
# Dual-Processor Lock Variable Unit

This block is shared by two processors and holds sixteen one-bit lock variables. They sit in a reserved sixteen-byte address window at 0xFFFFFFE0 to 0xFFFFFFEF. Every byte address in the window names one variable, so the variable index is the low four address bits. Any access that decodes into the window is claimed here and must not be passed on to main memory.

A load is an atomic test-and-set. It returns the variable's old value in bit 0 and sets the variable to 1 in the same step. Software spins until a load returns zero. A store writes bit 0 of its data into the variable, so storing zero releases the lock.

A store also acts as a fence. It is held back while the issuing processor reports that some of its earlier stores are not yet visible to the other processor. A load that finds the lock already taken raises a one-cycle flag, which a multithreaded core can treat like a cache miss and use to switch threads.

Top module: `mp_lock_unit`

## Requirements
- R1: `claim[p]` is 1 only when `req_valid[p]` is 1 and `req_addr[p]` lies in 0xFFFFFFE0..0xFFFFFFEF. Outside the window, `claim`, `ready` and `stall` stay 0 and no variable changes.
- R2: A load that is served (`ready[p]`=1 in the same cycle as the request) returns the variable's value in bit 0 of `rsp_rdata[p]`, with bits 31..1 zero. Stores, and requests that are not served, return all zeros.
- R3: A served load sets the addressed variable to 1 at the next clock edge.
- R4: A served store writes bit 0 of `req_wdata[p]` into the addressed variable at the next clock edge. Bits 31..1 of the data are ignored.
- R5: After reset, all sixteen variables read 0.
- R6: While `fence_pend[p]` is 1, a store from processor p is not served: `ready`=0, `stall`=1, and the variable is unchanged. The store is served in the first cycle in which `fence_pend[p]` is 0.
- R7: When both processors claim the same variable in one cycle, processor 0's request blocks processor 1's. Processor 1 gets `ready`=0 and `stall`=1 and must retry.
- R8: When both processors claim different variables in one cycle, both are served in that cycle.
- R9: `lock_busy[p]` is 1 exactly when a served load of processor p returns 1.
- R10: `stall[p]` equals `claim[p]` and not `ready[p]`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 2 | Request valid, one bit per processor |
| req_write | input | 2 | 1 = store, 0 = load |
| req_addr | input | 2x32 | Byte address per processor |
| req_wdata | input | 2x32 | Store data per processor |
| fence_pend | input | 2 | Earlier stores of that processor not yet visible |
| claim | output | 2 | Access belongs to the lock window |
| ready | output | 2 | Access served this cycle |
| stall | output | 2 | Claimed access held this cycle |
| rsp_rdata | output | 2x32 | Load result |
| lock_busy | output | 2 | Served load found the lock taken |

## Verification
A variable can be reached by both processors in the same cycle. This happens either as two loads racing for one lock, or as a pending fenced store on processor 0 meeting a load from processor 1. The stimulus table drives these collisions on a shared index, and also drives a same-cycle pair on different indices. Each case is judged by which side gets `ready`, by the value each side reads, and by what a later solo load returns, which shows whether exactly one winner set the lock.

// File: rtl/mp_lock_unit.sv
module mp_lock_unit #(
  parameter logic [31:0] BASE = 32'hFFFF_FFE0,
  parameter int NVAR = 16,
  parameter int DW = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [1:0]          req_valid,
  input  logic [1:0]          req_write,
  input  logic [1:0][31:0]    req_addr,
  input  logic [1:0][DW-1:0]  req_wdata,
  input  logic [1:0]          fence_pend,
  output logic [1:0]          claim,
  output logic [1:0]          ready,
  output logic [1:0]          stall,
  output logic [1:0][DW-1:0]  rsp_rdata,
  output logic [1:0]          lock_busy
);
  localparam int IW = $clog2(NVAR);

  logic [NVAR-1:0]      lock_q, lock_d;
  logic [1:0][IW-1:0]   idx;
  logic [1:0]           cur;
  logic                 collide;

  for (genvar p = 0; p < 2; p++) begin : g_port
    assign idx[p]       = req_addr[p][IW-1:0];
    assign claim[p]     = req_valid[p] && (req_addr[p][31:IW] == BASE[31:IW]);
    assign cur[p]       = lock_q[idx[p]];
    assign stall[p]     = claim[p] & ~ready[p];
    assign rsp_rdata[p] = (ready[p] && !req_write[p]) ? {{(DW-1){1'b0}}, cur[p]} : '0;
    assign lock_busy[p] = ready[p] & ~req_write[p] & cur[p];
  end

  assign collide  = claim[0] & claim[1] & (idx[0] == idx[1]);
  assign ready[0] = claim[0] & ~(req_write[0] & fence_pend[0]);
  assign ready[1] = claim[1] & ~collide & ~(req_write[1] & fence_pend[1]);

  always_comb begin
    lock_d = lock_q;
    for (int p = 0; p < 2; p++)
      if (ready[p]) lock_d[idx[p]] = req_write[p] ? req_wdata[p][0] : 1'b1;
  end

  always_ff @(posedge clk)
    if (!rst_n) lock_q <= '0;
    else        lock_q <= lock_d;
endmodule

module mp_lock_unit_chk #(parameter int NVAR = 16) (
  input logic            clk,
  input logic            rst_n,
  input logic [1:0]      claim,
  input logic [1:0]      ready,
  input logic [1:0]      stall,
  input logic [1:0]      req_write,
  input logic [1:0]      fence_pend,
  input logic [1:0][31:0] req_addr,
  input logic [1:0][31:0] rsp_rdata,
  input logic [1:0]      lock_busy,
  input logic [NVAR-1:0] lock_q
);
  localparam int IW = $clog2(NVAR);

  assert_ready_in_window_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ready[0] |-> claim[0]);
  assert_rdata_upper_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_rdata[1][31:1] == '0);
  assert_load_sets_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ready[0] && !req_write[0]) |=> lock_q[$past(req_addr[0][IW-1:0])]);
  assert_fence_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ready[0] && req_write[0]) |-> !fence_pend[0]);
  assert_same_var_priority_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (claim[0] && claim[1] && req_addr[0][IW-1:0] == req_addr[1][IW-1:0]) |-> !ready[1]);
  assert_busy_reads_one_R9: assert property (@(posedge clk) disable iff (!rst_n)
    lock_busy[1] |-> (ready[1] && rsp_rdata[1][0]));
  assert_stall_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(stall[0] && ready[0]));
endmodule

bind mp_lock_unit mp_lock_unit_chk #(.NVAR(NVAR)) u_chk (
  .clk(clk), .rst_n(rst_n), .claim(claim), .ready(ready), .stall(stall),
  .req_write(req_write), .fence_pend(fence_pend), .req_addr(req_addr),
  .rsp_rdata(rsp_rdata), .lock_busy(lock_busy), .lock_q(lock_q));

// File: tb/mp_lock_unit_test.sv
module mp_lock_unit_test;
  logic clk = 0, rst_n = 0;
  logic [1:0] req_valid = 0, req_write = 0, fence_pend = 0;
  logic [1:0][31:0] req_addr = '0, req_wdata = '0;
  logic [1:0] claim, ready, stall, lock_busy;
  logic [1:0][31:0] rsp_rdata;
  int checks = 0, fails = 0;

  always #4 clk = ~clk;

  mp_lock_unit uut (.*);

  // in: {valid,write,data,fence, idx}; exp: {ready,rdata0,stall,busy}
  localparam int NV = 12;
  localparam logic [23:0] TBL [NV] = '{
    {4'b1000,4'd3,  4'b0000,4'd0,  4'b1000,4'b0000}, // R2 R3
    {4'b1000,4'd3,  4'b1000,4'd5,  4'b1101,4'b1000}, // R8 R9
    {4'b1101,4'd3,  4'b1000,4'd3,  4'b0010,4'b0010}, // R6 R7
    {4'b1100,4'd3,  4'b0000,4'd0,  4'b1000,4'b0000}, // R6 R4
    {4'b1000,4'd3,  4'b1000,4'd3,  4'b1000,4'b0010}, // R7
    {4'b0000,4'd0,  4'b1000,4'd3,  4'b0000,4'b1101}, // R3 R9
    {4'b0000,4'd0,  4'b1100,4'd5,  4'b0000,4'b1000}, // R4
    {4'b0000,4'd0,  4'b1000,4'd5,  4'b0000,4'b1000}, // R4
    {4'b1110,4'd9,  4'b1100,4'd9,  4'b1000,4'b0010}, // R7 R4
    {4'b0000,4'd0,  4'b1000,4'd9,  4'b0000,4'b1101}, // R4 R9
    {4'b1111,4'd14, 4'b0000,4'd0,  4'b0010,4'b0000}, // R6 R10
    {4'b1000,4'd14, 4'b0000,4'd0,  4'b1000,4'b0000}  // R6
  };

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic drive(input int p, input logic [7:0] f);
    req_valid[p]  = f[7];
    req_write[p]  = f[6];
    req_wdata[p]  = {31'h7FFF_FFFF, f[5]};
    fence_pend[p] = f[4];
    req_addr[p]   = {28'hFFFF_FFE, f[3:0]};
  endtask

  task automatic expect_port(input int p, input string tag, input logic [3:0] e);
    check({tag, " ready/stall/busy"}, {61'd0, ready[p], stall[p], lock_busy[p]},
          {61'd0, e[3], e[1], e[0]});
    check({tag, " rdata"}, {32'd0, rsp_rdata[p]}, {63'd0, e[2]});
    check({tag, " claim"}, {63'd0, claim[p]}, {63'd0, req_valid[p]});
  endtask

  task automatic do_reset;
    @(negedge clk); rst_n = 0; req_valid = 0;
    @(negedge clk); @(negedge clk); rst_n = 1;
  endtask

  initial begin
    do_reset();
    #2 check("R5 idle outputs", {60'd0, claim, ready}, 64'd0);

    // R1: addresses just outside the window
    @(negedge clk);
    req_valid = 2'b11; req_write = 2'b11; fence_pend = 0;
    req_addr[0] = 32'hFFFF_FFF0; req_wdata[0] = 32'h1;
    req_addr[1] = 32'hFFFF_FFDF; req_wdata[1] = 32'h1;
    #2 check("R1 outside window", {58'd0, claim, ready, stall}, 64'd0);
    @(negedge clk); req_valid = 0;

    // R5 and R1: every variable still reads 0
    for (int i = 0; i < 16; i++) begin
      @(negedge clk);
      drive(0, {4'b1000, i[3:0]});
      #2 check($sformatf("R5 reset value var %0d", i), {32'd0, rsp_rdata[0]}, 64'd0);
    end
    @(negedge clk); req_valid = 0;

    do_reset();
    for (int v = 0; v < NV; v++) begin
      @(negedge clk);
      drive(0, TBL[v][23:16]);
      drive(1, TBL[v][15:8]);
      #2;
      expect_port(0, $sformatf("vec%0d p0", v), TBL[v][7:4]);
      expect_port(1, $sformatf("vec%0d p1", v), TBL[v][3:0]);
    end
    @(negedge clk); req_valid = 0;

    // R6: a fenced store waits several cycles, then lands once released
    @(negedge clk);
    drive(1, {4'b1111, 4'd7});
    repeat (3) begin
      #2 check("R6 fenced store stalls", {62'd0, ready[1], stall[1]}, 64'd1);
      @(negedge clk);
    end
    fence_pend[1] = 0;
    #2 check("R6 released store served", {63'd0, ready[1]}, 64'd1);
    @(negedge clk);
    drive(1, {4'b1000, 4'd7});
    #2 check("R4 stored one reads back", {32'd0, rsp_rdata[1]}, 64'd1);
    check("R9 busy on taken lock", {63'd0, lock_busy[1]}, 64'd1);
    @(negedge clk); req_valid = 0;

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    #400000;
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule